// File: doc/BRIEF.md
# HDLC Bus Access Controller

This block lets one station share a single open-drain (wired-AND) line with several other masters that all send HDLC-framed traffic. An upstream framer hands it the frame one bit at a time, already carrying flags and CRC. The block treats those bits as opaque. It does not drive the line high. It pulls the line low for a 0 bit and releases it for a 1 bit. A separate monitor input carries the real line level back to the block.

Before a frame may start, the line must have read back as 1 on a run of consecutive bit enables. The run is 8 in normal mode and 10 when the long-wait input is set. After a successful frame the block also demands 10 idle bits once, which gives the other stations a fair turn. While sending, the block compares the synchronized monitor level against the bit it is currently presenting. If it released the line for a 1 but reads a 0, another station has won the line. The block stops at once, flags a collision and goes back to waiting.

The controller has two states:
- **ST_WAIT**: counts idle bit times.
- **ST_SEND**: presents bits to the line.

The transitions are:
- **start** (ST_WAIT to ST_SEND): the idle run is long enough and the framer offers a bit on a bit enable.
- **clash** (ST_SEND to ST_WAIT): a collision is detected.
- **finish** (ST_SEND to ST_WAIT): the bit marked last has had its full bit time, and a done pulse is given.
- **underrun** (ST_SEND to ST_WAIT): the framer has no bit ready at a bit enable. The frame is dropped without done.

Top module: `hdlc_bus_access`

## Requirements
- R1: While reset is held, the line is released and busy, collision, done and tx_ready are all 0.
- R2: With wait_long low and no recent own frame, the first bit is accepted on the first bit enable after 8 consecutive bit enables that each sampled the line as 1. Counted from reset release, that is the 9th bit enable.
- R3: With wait_long high, 10 consecutive idle bit times are required, so transmission starts on the 11th bit enable.
- R4: Any bit enable that samples the line as 0 restarts the idle count from zero.
- R5: After a frame ends with done, the next frame needs 10 idle bit times even with wait_long low. It therefore starts on the 11th bit enable after the done pulse.
- R6: While busy, a 0 bit pulls the line low and a 1 bit releases it. Exactly one framer bit is accepted per bit enable, tx_ready is only high in bit-enable cycles, and bits appear on the line in the order accepted.
- R7: When the block presents a 1 but the settled monitor reads 0, it asserts collision for exactly one cycle with the line released. It then drops busy and gives no done for that frame.
- R8: done is a one-cycle pulse on the bit enable that ends the bit marked tx_last, after which busy is 0.
- R9: When two stations start together on the wired-AND line, the one presenting the first differing 0 keeps the line without a collision. Its whole frame appears intact on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle pulse per bit time |
| wait_long | input | 1 | 1 selects the 10-bit idle wait, 0 the 8-bit wait |
| tx_valid | input | 1 | Framer has a bit to offer |
| tx_data | input | 1 | Offered frame bit |
| tx_last | input | 1 | Offered bit is the final bit of the frame |
| tx_ready | output | 1 | Bit is taken this cycle (when tx_valid) |
| mon_in | input | 1 | Asynchronous read-back of the shared line |
| bus_drive_low | output | 1 | 1 pulls the open-drain line low |
| busy | output | 1 | Station is sending a frame |
| collision | output | 1 | One-cycle pulse when a lost arbitration is detected |
| done | output | 1 | One-cycle pulse when a frame completes without collision |

## Verification
The assertions watch several properties on every cycle:
- The line is pulled low only while busy, and tx_ready never appears outside a bit enable.
- A collision always has the line released and always leaves ST_SEND. Collision and done never coincide.
- A line sample of 0 clears the idle count.
- No frame starts before the 8-bit run, or before the full 10-bit run when wait_long is set.

Other behaviours need two stations on a shared line and a framer model, so only the bench scenarios can show them:
- which station wins arbitration;
- that the winner's bits survive unchanged;
- the exact bit enable on which each wait ends, including the fairness wait after a completed frame.

// File: rtl/hdlc_bus_pkg.sv
package hdlc_bus_pkg;

    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_SEND = 1'b1
    } hba_state_e;

endpackage

// File: rtl/hba_mon_sync.sv
module hba_mon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Resets to 1 so an idle line is assumed until the first real samples arrive.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/hba_idle_count.sv
module hba_idle_count #(
    parameter int LIMIT = 10,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          bit_en,
    input  logic          line_idle,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (bit_en) begin
            if (!line_idle) begin
                count <= '0;
            end else if (count != TOP) begin
                count <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hdlc_bus_access.sv
module hdlc_bus_access
    import hdlc_bus_pkg::*;
#(
    parameter int SHORT_WAIT  = 8,
    parameter int LONG_WAIT   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic wait_long,
    input  logic tx_valid,
    input  logic tx_data,
    input  logic tx_last,
    output logic tx_ready,
    input  logic mon_in,
    output logic bus_drive_low,
    output logic busy,
    output logic collision,
    output logic done
);
    localparam int CW = $clog2(LONG_WAIT + 1);
    localparam int PW = $clog2(SYNC_STAGES + 1);
    localparam logic [PW-1:0] SETTLE = PW'(SYNC_STAGES);
    localparam logic [CW-1:0] N_SHORT = CW'(SHORT_WAIT);
    localparam logic [CW-1:0] N_LONG  = CW'(LONG_WAIT);

    hba_state_e    state_q, state_d;
    logic          cur_bit_q;
    logic          last_q;
    logic [PW-1:0] phase_q;
    logic          fair_q;
    logic          mon_s;
    logic [CW-1:0] idle_cnt;
    logic [CW-1:0] need;
    logic          eligible;
    logic          clash;
    logic          take;

    hba_mon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mon_in),
        .sync_out (mon_s)
    );

    hba_idle_count #(.LIMIT(LONG_WAIT), .CW(CW)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state_q == ST_SEND),
        .bit_en    (bit_en),
        .line_idle (mon_s),
        .count     (idle_cnt)
    );

    assign need     = (wait_long || fair_q) ? N_LONG : N_SHORT;
    assign eligible = (idle_cnt >= need);
    // Read-back has settled for the bit on the line; a released 1 seen as 0 is a lost bit.
    assign clash    = (state_q == ST_SEND) && cur_bit_q && (phase_q == SETTLE) && !mon_s;
    assign take     = tx_ready && tx_valid;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (bit_en && tx_valid && eligible) state_d = ST_SEND;  // start
            ST_SEND: begin
                if (clash)                              state_d = ST_WAIT;   // clash
                else if (bit_en && (last_q || !tx_valid)) state_d = ST_WAIT; // finish / underrun
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // State register and bit datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_WAIT;
            cur_bit_q <= 1'b1;
            last_q    <= 1'b0;
            phase_q   <= '0;
            fair_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) begin
                cur_bit_q <= tx_data;
                last_q    <= tx_last;
                phase_q   <= '0;
            end else if (state_q == ST_SEND && phase_q != SETTLE) begin
                phase_q <= phase_q + 1'b1;
            end
            if (done) begin
                fair_q <= 1'b1;
            end else if (state_q == ST_WAIT && idle_cnt == N_LONG) begin
                fair_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        tx_ready      = 1'b0;
        bus_drive_low = 1'b0;
        busy          = 1'b0;
        collision     = 1'b0;
        done          = 1'b0;
        unique case (state_q)
            ST_WAIT: tx_ready = bit_en && eligible;
            ST_SEND: begin
                busy          = 1'b1;
                bus_drive_low = !cur_bit_q;
                collision     = clash;
                tx_ready      = bit_en && !clash && !last_q;
                done          = bit_en && !clash && last_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hba_checker.sv
module hba_checker #(
    parameter int SHORT_WAIT = 8,
    parameter int LONG_WAIT  = 10,
    parameter int CW         = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_en,
    input logic          wait_long,
    input logic          mon_s,
    input logic          tx_ready,
    input logic          busy,
    input logic          collision,
    input logic          done,
    input logic          bus_drive_low,
    input logic [CW-1:0] idle_cnt
);
    // R6
    ready_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> bit_en);

    // R6
    drive_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_low |-> busy);

    // R7
    coll_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> (busy && !bus_drive_low && !done));

    // R7
    coll_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collision |=> !busy);

    // R8
    done_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R4
    idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !mon_s) |=> (idle_cnt == '0));

    // R2
    short_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(idle_cnt) >= CW'(SHORT_WAIT)));

    // R3
    long_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(wait_long)) |-> ($past(idle_cnt) == CW'(LONG_WAIT)));
endmodule

bind hdlc_bus_access hba_checker #(
    .SHORT_WAIT (SHORT_WAIT),
    .LONG_WAIT  (LONG_WAIT),
    .CW         (CW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_en        (bit_en),
    .wait_long     (wait_long),
    .mon_s         (mon_s),
    .tx_ready      (tx_ready),
    .busy          (busy),
    .collision     (collision),
    .done          (done),
    .bus_drive_low (bus_drive_low),
    .idle_cnt      (idle_cnt)
);

// File: tb/hdlc_bus_access_bench.sv
`timescale 1ns/1ps
module hdlc_bus_access_bench;
    localparam int LEN = 12;
    localparam int NV  = 6;
    // {frame_a, frame_b, enable_a, enable_b, b_wins}; bits go out LSB first
    localparam logic [26:0] VEC [NV] = '{
        {12'h5A3, 12'h000, 1'b1, 1'b0, 1'b0},
        {12'h000, 12'hC3C, 1'b0, 1'b1, 1'b1},
        {12'h0F0, 12'h0F1, 1'b1, 1'b1, 1'b0},
        {12'h3FF, 12'h1FF, 1'b1, 1'b1, 1'b1},
        {12'hAAA, 12'hAA2, 1'b1, 1'b1, 1'b1},
        {12'h000, 12'h800, 1'b1, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, bit_en = 1'b0, ext_low = 1'b0;
    logic wl_a = 1'b0, wl_b = 1'b0, act_a = 1'b0, act_b = 1'b0;
    logic [LEN-1:0] frm_a = '0, frm_b = '0;
    logic [4:0] idx_a = '0, idx_b = '0;
    logic [2:0] div = '0;
    logic rdy_a = 1'b0, rdy_b = 1'b0, pb_a = 1'b0;
    int bcount = 0, start_a = 0, ndone_a = 0, ndone_b = 0, ncoll_a = 0, ncoll_b = 0;
    logic [15:0] cap = '0;
    int cap_n = 0;
    int nchk = 0, nfail = 0;

    logic drv_a, drv_b, busy_a, busy_b, coll_a, coll_b, done_a, done_b, tr_a, tr_b;
    wire line = !drv_a && !drv_b && !ext_low;
    wire tv_a = act_a && (idx_a < 5'(LEN));
    wire tv_b = act_b && (idx_b < 5'(LEN));
    wire td_a = (idx_a < 5'(LEN)) ? frm_a[idx_a[3:0]] : 1'b1;
    wire td_b = (idx_b < 5'(LEN)) ? frm_b[idx_b[3:0]] : 1'b1;
    wire tl_a = (idx_a == 5'(LEN - 1));
    wire tl_b = (idx_b == 5'(LEN - 1));

    hdlc_bus_access u_hdlc_bus_access (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wait_long(wl_a),
        .tx_valid(tv_a), .tx_data(td_a), .tx_last(tl_a), .tx_ready(tr_a),
        .mon_in(line), .bus_drive_low(drv_a), .busy(busy_a),
        .collision(coll_a), .done(done_a)
    );

    hdlc_bus_access u_peer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wait_long(wl_b),
        .tx_valid(tv_b), .tx_data(td_b), .tx_last(tl_b), .tx_ready(tr_b),
        .mon_in(line), .bus_drive_low(drv_b), .busy(busy_b),
        .collision(coll_b), .done(done_b)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_bits(input int n);
        repeat (n * 8) @(negedge clk);
        #1;
    endtask

    task automatic do_reset(input logic hold_low);
        @(negedge clk); #1;
        rst_n = 1'b0; act_a = 1'b0; act_b = 1'b0; idx_a = '0; idx_b = '0;
        ext_low = hold_low;
        repeat (4) @(negedge clk);
        #1;
        rst_n = 1'b1; bcount = 0; start_a = 0; ndone_a = 0; ncoll_a = 0;
    endtask

    // Bit-rate engine and framer/receiver models
    initial begin
        forever begin
            @(negedge clk);
            if (bit_en) begin
                bcount++;
                if (rdy_a) idx_a = idx_a + 1'b1;
                if (rdy_b) idx_b = idx_b + 1'b1;
            end
            bit_en = (div == 3'd7);
            div = div + 1'b1;
            #3;
            rdy_a = tr_a && tv_a;
            rdy_b = tr_b && tv_b;
            if (done_a) begin ndone_a++; act_a = 1'b0; end
            if (done_b) begin ndone_b++; act_b = 1'b0; end
            if (coll_a) begin ncoll_a++; act_a = 1'b0; end
            if (coll_b) begin ncoll_b++; act_b = 1'b0; end
            if (busy_a && !pb_a) start_a = bcount;
            pb_a = busy_a;
            if (div == 3'd4 && (busy_a || busy_b) && cap_n < 16) begin
                cap[cap_n] = line;
                cap_n++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk); #3;
        chk(!drv_a && !busy_a && !coll_a && !done_a && !tr_a, "R1", int'(busy_a), 0);
        chk(!drv_b && !busy_b && !coll_b && !done_b && !tr_b, "R1", int'(busy_b), 0);

        // R2: 8-bit wait from reset, then R5 fairness wait
        do_reset(1'b0);
        frm_a = 12'h9C5; act_a = 1'b1;
        wait (ndone_a == 1);
        chk(start_a == 9, "R2", start_a, 9);
        @(negedge clk); #1;
        bcount = 0; idx_a = '0; frm_a = 12'h36E; act_a = 1'b1;
        wait (ndone_a == 2);
        chk(start_a == 11, "R5", start_a, 11);

        // R3: long wait selected
        wl_a = 1'b1;
        do_reset(1'b0);
        frm_a = 12'h1B4; act_a = 1'b1;
        wait (ndone_a == 1);
        chk(start_a == 11, "R3", start_a, 11);
        wl_a = 1'b0;

        // R4: line held low for three bit enables restarts the count
        do_reset(1'b1);
        frm_a = 12'h0E7; act_a = 1'b1;
        wait (bcount == 3);
        #1 ext_low = 1'b0;
        wait (ndone_a == 1);
        chk(start_a == 12, "R4", start_a, 12);

        // Vector table: single senders and two-station contests
        for (int v = 0; v < NV; v++) begin
            logic [LEN-1:0] fa, fb, wf;
            logic ea, eb, wb;
            {fa, fb, ea, eb, wb} = VEC[v];
            wf = wb ? fb : fa;
            wait_bits(14);
            @(negedge clk); #1;
            frm_a = fa; frm_b = fb; idx_a = '0; idx_b = '0;
            ndone_a = 0; ndone_b = 0; ncoll_a = 0; ncoll_b = 0;
            cap = '0; cap_n = 0;
            act_a = ea; act_b = eb;
            wait_bits(20);
            if (wb) begin
                chk(ndone_b == 1, "R8", ndone_b, 1);
                chk(ncoll_b == 0, "R9", ncoll_b, 0);
                chk(ndone_a == 0 && ncoll_a == int'(ea), "R7", ncoll_a, int'(ea));
            end else begin
                chk(ndone_a == 1, "R8", ndone_a, 1);
                chk(ncoll_a == 0, "R9", ncoll_a, 0);
                chk(ndone_b == 0 && ncoll_b == int'(eb), "R7", ncoll_b, int'(eb));
            end
            // R6 / R9: winner's frame intact on the line
            chk(cap[LEN-1:0] == wf && cap_n == LEN, (ea && eb) ? "R9" : "R6",
                int'(cap[LEN-1:0]), int'(wf));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule